// File: doc/BRIEF.md
# Non-Preemptive Channel Service Scheduler

This block collects service requests from a bank of timer channels. It hands the single execution engine one channel at a time. The host programs a 2-bit priority level for each channel. When the engine is idle, the scheduler picks the best pending request. It then raises a busy indication and a one-cycle start pulse, and it publishes the chosen channel number. A context-switch unit uses that number to load the channel's registers and flags before the service thread runs.

Once a thread is granted, nothing interrupts it, including requests at a higher level. The thread ends in one of two ways: the engine reports its end instruction, or the host writes the self-clearing force-end bit. After the thread ends, the granted channel's pending request is cleared, and a new arbitration takes place in the following cycle. Requests that arrive while a thread runs are held until they can be served.

All pins are plain control and status signals. No payload stream flows through the block, so it has no valid/ready pair and no back-pressure. The context-switch unit must accept the channel number in the cycle that `start_o` is high. The number then stays stable on `grant_ch_o` for as long as `busy_o` is high.

Top module: `svc_sched`

## Requirements
- R1: After reset, `busy_o` and `start_o` are 0, `grant_ch_o` is 0, every channel priority is 0 and no request is pending.
- R2: A cycle with `prio_we_i` high stores `prio_val_i` as the level of channel `prio_ch_i`. The level encodings are 0 = disabled, 1 = low, 2 = middle and 3 = high.
- R3: A request on a channel at level 0 is latched but never granted while the level stays 0. The request stays pending and is served once the channel's level is raised.
- R4: Arbitration picks the highest level among pending enabled channels. Between channels at the same level, the lower channel number wins.
- R5: Arbitration happens only while idle. A request sampled at clock edge k on an idle scheduler gives `busy_o`=1, a one-cycle `start_o`=1 and the winner on `grant_ch_o` after edge k+1.
- R6: While a thread runs, `grant_ch_o` holds its value and no new grant is made, even for requests at a higher level.
- R7: `thread_end_i` sampled high while busy drops `busy_o` after that edge and clears the granted channel's pending request. The next grant can follow after the next edge.
- R8: A `force_end_i` pulse sampled while busy at edge k ends the thread, and `busy_o` falls after edge k+1.
- R9: A `force_end_i` pulse while idle has no effect. A `force_end_i` pulse in the same cycle as `thread_end_i` terminates only one thread, and the thread granted next keeps running.
- R10: Requests raised by other channels during a thread stay pending and are served later. A request on the ending channel in the ending cycle survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NCH | Per-channel service request, sampled every cycle |
| prio_we_i | input | 1 | Host write strobe for a channel priority |
| prio_ch_i | input | CW | Channel whose priority is written |
| prio_val_i | input | 2 | Priority level written (0 off, 1 low, 2 middle, 3 high) |
| force_end_i | input | 1 | Host write of 1 to the self-clearing force-end bit |
| thread_end_i | input | 1 | Engine executed its end instruction |
| busy_o | output | 1 | A service thread is running |
| start_o | output | 1 | One-cycle pulse at the start of a thread, telling the context unit to load the channel |
| grant_ch_o | output | CW | Channel number of the running thread |

## Verification
Arbitration is tried in three ways. The first enables one channel at a time at each level, which exposes indexing and latency errors on every channel number. The second requests all channels at one level, which must give strict ascending channel order and so tests tie-breaking. The third requests all channels with levels interleaved by channel number modulo three, which separates level ordering from index ordering. Directed sequences add a higher-level request arriving mid-thread, a disabled channel enabled later, force-end while busy, while idle and together with a normal end, and a re-request on the ending channel.

// File: rtl/svc_sched_pkg.sv
package svc_sched_pkg;
  localparam int PW   = 2;
  localparam int NLVL = 1 << PW;

  typedef enum logic [PW-1:0] {
    PRIO_OFF  = 2'd0,
    PRIO_LOW  = 2'd1,
    PRIO_MID  = 2'd2,
    PRIO_HIGH = 2'd3
  } prio_e;
endpackage

// File: rtl/svc_lowbit.sv
// Finds the lowest set bit of a vector.
module svc_lowbit #(
  parameter int N  = 32,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/svc_prio_regs.sv
// Host-written per-channel priority levels.
module svc_prio_regs import svc_sched_pkg::*; #(
  parameter int NCH = 32,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CW-1:0]     wch,
  input  logic [PW-1:0]     wval,
  output logic [NCH*PW-1:0] prio_all
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_all <= '0;
    end else if (we && (int'(wch) < NCH)) begin
      prio_all[int'(wch)*PW +: PW] <= wval;
    end
  end
endmodule

// File: rtl/svc_pick.sv
// Level-then-index arbiter: highest level wins, lowest channel breaks ties.
module svc_pick import svc_sched_pkg::*; #(
  parameter int NCH = 32,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]    pend,
  input  logic [NCH*PW-1:0] prio_all,
  output logic              win_vld,
  output logic [CW-1:0]     win_ch
);
  logic [NLVL-1:1][NCH-1:0] lvl_vec;
  logic [NLVL-1:1]          lvl_any;
  logic [NLVL-1:1][CW-1:0]  lvl_idx;

  for (genvar lv = 1; lv < NLVL; lv++) begin : g_lvl
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign lvl_vec[lv][c] = pend[c] && (prio_all[c*PW +: PW] == PW'(lv));
    end
    svc_lowbit #(.N(NCH), .IW(CW)) u_low (
      .vec (lvl_vec[lv]),
      .any (lvl_any[lv]),
      .idx (lvl_idx[lv])
    );
  end

  always_comb begin
    win_vld = 1'b0;
    win_ch  = '0;
    for (int lv = 1; lv < NLVL; lv++) begin
      if (lvl_any[lv]) begin
        win_vld = 1'b1;
        win_ch  = lvl_idx[lv];
      end
    end
  end
endmodule

// File: rtl/svc_sched.sv
module svc_sched import svc_sched_pkg::*; #(
  parameter int NCH = 32,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           prio_we_i,
  input  logic [CW-1:0]  prio_ch_i,
  input  logic [PW-1:0]  prio_val_i,
  input  logic           force_end_i,
  input  logic           thread_end_i,
  output logic           busy_o,
  output logic           start_o,
  output logic [CW-1:0]  grant_ch_o
);
  logic [NCH*PW-1:0] prio_all;
  logic [NCH-1:0]    pend_q;
  logic [NCH-1:0]    clr_vec;
  logic              fe_q;
  logic              busy_q;
  logic              start_q;
  logic [CW-1:0]     gch_q;
  logic              win_vld;
  logic [CW-1:0]     win_ch;
  logic              end_evt;

  svc_prio_regs #(.NCH(NCH), .CW(CW)) u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (prio_we_i),
    .wch      (prio_ch_i),
    .wval     (prio_val_i),
    .prio_all (prio_all)
  );

  svc_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .pend     (pend_q),
    .prio_all (prio_all),
    .win_vld  (win_vld),
    .win_ch   (win_ch)
  );

  // A normal end and a pending force-end merge into one termination.
  assign end_evt = busy_q && (thread_end_i || fe_q);
  assign clr_vec = end_evt ? (NCH'(1) << gch_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      fe_q    <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      gch_q   <= '0;
    end else begin
      pend_q  <= (pend_q & ~clr_vec) | req_i;
      fe_q    <= force_end_i && busy_q && !end_evt;
      start_q <= 1'b0;
      if (busy_q) begin
        if (end_evt) busy_q <= 1'b0;
      end else if (win_vld) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        gch_q   <= win_ch;
      end
    end
  end

  assign busy_o     = busy_q;
  assign start_o    = start_q;
  assign grant_ch_o = gch_q;
endmodule

// File: rtl/svc_sched_chk.sv
module svc_sched_chk import svc_sched_pkg::*; #(
  parameter int NCH = 32,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              thread_end_i,
  input logic              fe_q,
  input logic              busy_o,
  input logic              start_o,
  input logic [CW-1:0]     grant_ch_o,
  input logic [NCH*PW-1:0] prio_all
);
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(busy_o)); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o); // R5
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !thread_end_i && !fe_q) |=> (busy_o && !start_o && $stable(grant_ch_o))); // R6
  AST_END_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && thread_end_i) |=> !busy_o); // R7
  AST_FORCE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && fe_q) |=> !busy_o); // R8
  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (prio_all[int'(grant_ch_o)*PW +: PW] != '0)); // R3
endmodule

bind svc_sched svc_sched_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .thread_end_i (thread_end_i),
  .fe_q         (fe_q),
  .busy_o       (busy_o),
  .start_o      (start_o),
  .grant_ch_o   (grant_ch_o),
  .prio_all     (prio_all)
);

// File: tb/svc_sched_bench.sv
`timescale 1ns/1ps
module svc_sched_bench;
  localparam int NCH = 32;
  localparam int CW  = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] req_i = '0;
  logic           prio_we_i = 1'b0;
  logic [CW-1:0]  prio_ch_i = '0;
  logic [1:0]     prio_val_i = '0;
  logic           force_end_i = 1'b0;
  logic           thread_end_i = 1'b0;
  logic           busy_o, start_o;
  logic [CW-1:0]  grant_ch_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  svc_sched #(.NCH(NCH), .CW(CW)) u_svc_sched (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_we_i(prio_we_i),
    .prio_ch_i(prio_ch_i), .prio_val_i(prio_val_i), .force_end_i(force_end_i),
    .thread_end_i(thread_end_i), .busy_o(busy_o), .start_o(start_o),
    .grant_ch_o(grant_ch_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_prio(input int c, input int v);
    prio_we_i = 1'b1; prio_ch_i = CW'(c); prio_val_i = 2'(v);
    tick();
    prio_we_i = 1'b0;
  endtask

  task automatic raise(input logic [NCH-1:0] m);
    req_i = m;
    tick();
    req_i = '0;
  endtask

  task automatic wait_grant(output int ch);
    int n = 0;
    while (!start_o && n < 8) begin tick(); n++; end
    ch = start_o ? int'(grant_ch_o) : -1;
  endtask

  task automatic end_thread(input string req);
    thread_end_i = 1'b1;
    tick();
    thread_end_i = 1'b0;
    check(busy_o == 1'b0, req, busy_o, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int g;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check(busy_o == 0 && start_o == 0, "R1 idle", busy_o, 0);
    check(grant_ch_o == 0, "R1 grant", grant_ch_o, 0);

    // R2 R5: each channel alone, level cycling, exact latency
    for (int c = 0; c < NCH; c++) begin
      set_prio(c, (c % 3) + 1);
      raise(NCH'(1) << c);
      check(busy_o == 0, "R5 not early", busy_o, 0);
      tick();
      check(start_o && busy_o && grant_ch_o == CW'(c), "R5 single grant", int'(grant_ch_o), c);
      tick();
      check(start_o == 0 && busy_o, "R5 start pulse", start_o, 0);
      end_thread("R7 end");
    end

    // R4 tie-break: all at middle level, ascending order
    for (int c = 0; c < NCH; c++) set_prio(c, 2);
    raise('1);
    for (int c = 0; c < NCH; c++) begin
      wait_grant(g);
      check(g == c, "R4 tie order", g, c);
      end_thread("R7 end");
    end

    // R4 level ordering: level = c%3+1
    for (int c = 0; c < NCH; c++) set_prio(c, (c % 3) + 1);
    raise('1);
    for (int lv = 3; lv >= 1; lv--) begin
      for (int c = 0; c < NCH; c++) begin
        if ((c % 3) + 1 == lv) begin
          wait_grant(g);
          check(g == c, "R4 level order", g, c);
          end_thread("R7 end");
        end
      end
    end

    // R3 disabled channel stays pending
    set_prio(9, 0);
    raise(NCH'(1) << 9);
    repeat (5) tick();
    check(busy_o == 0, "R3 disabled no grant", busy_o, 0);
    set_prio(9, 2);
    wait_grant(g);
    check(g == 9, "R3 served once enabled", g, 9);
    end_thread("R7 end");

    // R6 no preemption, R10 pending kept
    set_prio(7, 1);
    set_prio(20, 3);
    raise(NCH'(1) << 7);
    wait_grant(g);
    check(g == 7, "R6 low granted", g, 7);
    raise(NCH'(1) << 20);
    for (int i = 0; i < 5; i++) begin
      check(busy_o && grant_ch_o == 7 && !start_o, "R6 held", int'(grant_ch_o), 7);
      tick();
    end
    end_thread("R7 end");
    wait_grant(g);
    check(g == 20, "R10 later served", g, 20);
    // R10 re-request on ending channel survives
    req_i = NCH'(1) << 20;
    end_thread("R7 end");
    req_i = '0;
    wait_grant(g);
    check(g == 20, "R10 re-request", g, 20);
    end_thread("R7 end");

    // R8 force-end while busy
    raise(NCH'(1) << 3);
    wait_grant(g);
    force_end_i = 1'b1;
    tick();
    force_end_i = 1'b0;
    check(busy_o == 1, "R8 one cycle later", busy_o, 1);
    tick();
    check(busy_o == 0, "R8 force ends", busy_o, 0);

    // R9 force-end while idle ignored
    force_end_i = 1'b1;
    tick();
    force_end_i = 1'b0;
    raise(NCH'(1) << 11);
    wait_grant(g);
    check(g == 11, "R9 idle force grant", g, 11);
    repeat (4) tick();
    check(busy_o && grant_ch_o == 11, "R9 idle force no effect", busy_o, 1);

    // R9 force and end together: single termination
    raise(NCH'(1) << 12);
    force_end_i = 1'b1;
    thread_end_i = 1'b1;
    tick();
    force_end_i = 1'b0;
    thread_end_i = 1'b0;
    check(busy_o == 0, "R9 combined end", busy_o, 0);
    tick();
    check(start_o && grant_ch_o == 12, "R9 next grant", int'(grant_ch_o), 12);
    repeat (4) tick();
    check(busy_o && grant_ch_o == 12, "R9 next thread survives", busy_o, 1);
    end_thread("R7 end");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule